// File: doc/BRIEF.md
# Bidirectional Dual-FIFO Processor Mailbox

This block passes bytes between a 32-bit host processor and an 8-bit audio processor. It holds two independent byte queues, one for each direction. Each side pushes into one queue and pops from the other, and both sides use a single data address to do so. Each side can also read a status byte. In that byte, one bit reports whether the queue this side pops from holds data. Every other bit reads as one.

The host sees one 32-bit word. The lowest byte lane of that word is the data byte. The highest byte lane is the status byte. The two middle lanes read as all ones. A host read pops the audio-to-host queue only when byte enable 0 is set. A host read that enables only the status lane leaves both queues untouched.

The audio side sees an I/O port pair, decoded on the low 8 address bits only. Port 0x90 is the data port: a read pops the host-to-audio queue and a write pushes the audio-to-host queue. Port 0x91 is the status port. Read data is combinational from the queue head, and a pop takes effect at the clock edge that ends the access. One synchronous reset empties both queues.

Top module: `mbox_dual_fifo`

## Requirements
- R1: After reset both queues are empty, and both status bytes read 0xFD.
- R2: A host write with byte enable 0 set pushes hostWdata[7:0] into the host-to-audio queue. Audio reads of port 0x90 return those bytes in the order they were written, and each such read pops one byte.
- R3: An audio write to port 0x90 pushes audWdata into the audio-to-host queue. Host reads with byte enable 0 set return those bytes in hostRdata[7:0], in order, and each such read pops one byte.
- R4: An audio read of port 0x91 returns a status byte. Its bit 1 is 1 when the host-to-audio queue holds data and 0 when it is empty. Every other bit is 1, so the byte is 0xFF or 0xFD.
- R5: hostRdata[31:24] is a status byte whose bit 1 is 1 when the audio-to-host queue holds data. Every other bit is 1. hostRdata[23:8] always reads 0xFFFF.
- R6: A host read with byte enable 0 clear pops nothing. The next read with byte enable 0 set still returns the same head byte.
- R7: Audio address bits above bit 7 are ignored. Address low byte 0x90 is the data port and 0x91 is the status port. A read of any other low byte returns 0xFF and pops nothing.
- R8: Each queue holds 1024 bytes. A push into a full queue is dropped, and the 1024 stored bytes are kept unchanged.
- R9: A data read from an empty queue returns 0xFF on the data byte and changes no queue state.
- R10: A host write with byte enable 0 clear pushes nothing.
- R11: A push and a pop on the same queue in the same cycle both take effect. Exception: a pop from an empty queue or a push into a full queue is judged on the state before that cycle, and is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset; empties both queues |
| hostSel | input | 1 | Host accesses the mailbox word this cycle |
| hostRe | input | 1 | Host read strobe |
| hostWe | input | 1 | Host write strobe |
| hostBe | input | 4 | Host byte enables; bit 0 is the data lane, bit 3 the status lane |
| hostWdata | input | 32 | Host write word; only bits 7:0 are stored |
| hostRdata | output | 32 | {status, 16'hFFFF, data byte} |
| audAddr | input | 16 | Audio I/O address; only bits 7:0 are decoded |
| audRd | input | 1 | Audio I/O read strobe |
| audWr | input | 1 | Audio I/O write strobe |
| audWdata | input | 8 | Audio write byte |
| audRdata | output | 8 | Audio read byte: queue head, status, or 0xFF |

## Verification
On every cycle, the assertions check four things:
- the queues are empty right after reset;
- both status bytes agree with the occupancy of the queue they describe;
- a status-only host read leaves the audio-to-host occupancy unchanged;
- occupancy never exceeds 1024, and a full queue with no pop stays full; an empty data read returns 0xFF.

Only the bench scenarios can show the following:
- byte order through each queue;
- that upper audio address bits and disabled byte lanes really have no effect on stored data;
- that a dropped push into a full queue leaves exactly the first 1024 bytes;
- how simultaneous pushes and pops from both sides interleave.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Strobes for one queue
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

  // What the audio read port is looking at
  typedef enum logic [1:0] {
    AUD_IDLE = 2'd0,
    AUD_DATA = 2'd1,
    AUD_STAT = 2'd2
  } audSel_e;

  // Control-to-datapath bundle
  typedef struct packed {
    fifoStrobe_t h2a;
    fifoStrobe_t a2h;
    audSel_e     audSel;
  } mboxCtl_t;

  // Status byte: all ones except the data-available bit
  function automatic logic [7:0] statusByte(input logic isEmpty, input int bitPos);
    logic [7:0] s;
    s = '1;
    s[bitPos] = !isEmpty;
    return s;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic             pushOk;
  logic             popOk;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Refusals are judged on the state before this cycle
  assign pushOk = pushReq && !full;
  assign popOk  = popReq && !empty;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign headData = mem[rdPtr];

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int         AUD_ADDR_W = 16,
  parameter logic [7:0] DATA_PORT  = 8'h90,
  parameter logic [7:0] STAT_PORT  = 8'h91,
  parameter int         DATA_LANE  = 0
) (
  input  logic                  hostSel,
  input  logic                  hostRe,
  input  logic                  hostWe,
  input  logic [3:0]            hostBe,
  input  logic [AUD_ADDR_W-1:0] audAddr,
  input  logic                  audRd,
  input  logic                  audWr,
  output mboxCtl_t              ctl
);

  logic [7:0] audLow;
  logic       hostLaneHit;
  logic       audIsData;
  logic       audIsStat;
  logic [AUD_ADDR_W-9:0] unusedAddrHigh;
  logic [3:0]            unusedBe;

  assign audLow         = audAddr[7:0];
  assign unusedAddrHigh = audAddr[AUD_ADDR_W-1:8];
  assign unusedBe       = hostBe;

  assign hostLaneHit = hostSel && hostBe[DATA_LANE];
  assign audIsData   = (audLow == DATA_PORT);
  assign audIsStat   = (audLow == STAT_PORT);

  always_comb begin
    ctl          = '0;
    ctl.h2a.push = hostLaneHit && hostWe;
    ctl.a2h.pop  = hostLaneHit && hostRe;
    ctl.h2a.pop  = audRd && audIsData;
    ctl.a2h.push = audWr && audIsData;
    if (audIsData)      ctl.audSel = AUD_DATA;
    else if (audIsStat) ctl.audSel = AUD_STAT;
    else                ctl.audSel = AUD_IDLE;
  end

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int HOST_W   = 32,
  parameter int STAT_BIT = 1,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int MID_W   = HOST_W - 16
) (
  input  logic              clk,
  input  logic              rst,
  input  mboxCtl_t          ctl,
  input  logic [7:0]        hostByte,
  input  logic [7:0]        audByte,
  output logic [HOST_W-1:0] hostRdata,
  output logic [7:0]        audRdata,
  output logic [CW-1:0]     h2aCount,
  output logic [CW-1:0]     a2hCount
);

  // index 0: host-to-audio, index 1: audio-to-host
  logic [1:0]    pushV;
  logic [1:0]    popV;
  logic [1:0]    emptyV;
  logic [1:0]    unusedFull;
  logic [7:0]    inV   [2];
  logic [7:0]    headV [2];
  logic [CW-1:0] cntV  [2];

  assign pushV = {ctl.a2h.push, ctl.h2a.push};
  assign popV  = {ctl.a2h.pop,  ctl.h2a.pop};
  assign inV[0] = hostByte;
  assign inV[1] = audByte;

  for (genvar g = 0; g < 2; g++) begin : gQueue
    mbox_fifo #(.DEPTH(DEPTH), .WIDTH(8)) uFifo (
      .clk      (clk),
      .rst      (rst),
      .pushReq  (pushV[g]),
      .popReq   (popV[g]),
      .pushData (inV[g]),
      .headData (headV[g]),
      .empty    (emptyV[g]),
      .full     (unusedFull[g]),
      .count    (cntV[g])
    );
  end

  assign h2aCount = cntV[0];
  assign a2hCount = cntV[1];

  assign hostRdata = {statusByte(emptyV[1], STAT_BIT),
                      {MID_W{1'b1}},
                      emptyV[1] ? 8'hFF : headV[1]};

  always_comb begin
    case (ctl.audSel)
      AUD_DATA: audRdata = emptyV[0] ? 8'hFF : headV[0];
      AUD_STAT: audRdata = statusByte(emptyV[0], STAT_BIT);
      default:  audRdata = 8'hFF;
    endcase
  end

endmodule

// File: rtl/mbox_dual_fifo.sv
module mbox_dual_fifo
  import mbox_pkg::*;
#(
  parameter int         DEPTH      = 1024,
  parameter int         AUD_ADDR_W = 16,
  parameter logic [7:0] DATA_PORT  = 8'h90,
  parameter logic [7:0] STAT_PORT  = 8'h91,
  parameter int         STAT_BIT   = 1,
  localparam int        CW         = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hostSel,
  input  logic                  hostRe,
  input  logic                  hostWe,
  input  logic [3:0]            hostBe,
  input  logic [31:0]           hostWdata,
  output logic [31:0]           hostRdata,
  input  logic [AUD_ADDR_W-1:0] audAddr,
  input  logic                  audRd,
  input  logic                  audWr,
  input  logic [7:0]            audWdata,
  output logic [7:0]            audRdata
);

  mboxCtl_t      ctl;
  logic [CW-1:0] h2aCount;
  logic [CW-1:0] a2hCount;
  logic [23:0]   unusedWdata;

  assign unusedWdata = hostWdata[31:8];

  mbox_ctrl #(
    .AUD_ADDR_W (AUD_ADDR_W),
    .DATA_PORT  (DATA_PORT),
    .STAT_PORT  (STAT_PORT),
    .DATA_LANE  (0)
  ) uCtrl (
    .hostSel (hostSel),
    .hostRe  (hostRe),
    .hostWe  (hostWe),
    .hostBe  (hostBe),
    .audAddr (audAddr),
    .audRd   (audRd),
    .audWr   (audWr),
    .ctl     (ctl)
  );

  mbox_datapath #(
    .DEPTH    (DEPTH),
    .HOST_W   (32),
    .STAT_BIT (STAT_BIT)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .hostByte  (hostWdata[7:0]),
    .audByte   (audWdata),
    .hostRdata (hostRdata),
    .audRdata  (audRdata),
    .h2aCount  (h2aCount),
    .a2hCount  (a2hCount)
  );

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int         DEPTH      = 1024,
  parameter int         AUD_ADDR_W = 16,
  parameter logic [7:0] DATA_PORT  = 8'h90,
  parameter logic [7:0] STAT_PORT  = 8'h91,
  localparam int        CW         = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hostSel,
  input logic                  hostRe,
  input logic [3:0]            hostBe,
  input logic [31:0]           hostRdata,
  input logic [AUD_ADDR_W-1:0] audAddr,
  input logic                  audRd,
  input logic                  audWr,
  input logic [7:0]            audRdata,
  input logic [CW-1:0]         h2aCount,
  input logic [CW-1:0]         a2hCount
);

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (h2aCount == '0 && a2hCount == '0));

  assert_aud_status_R4: assert property (@(posedge clk) disable iff (rst)
    (audRd && audAddr[7:0] == STAT_PORT) |->
      (audRdata == ((h2aCount == '0) ? 8'hFD : 8'hFF)));

  assert_host_status_R5: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostRe) |->
      (hostRdata[31:8] == {((a2hCount == '0) ? 8'hFD : 8'hFF), 16'hFFFF}));

  assert_status_read_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostRe && !hostBe[0] && !(audWr && audAddr[7:0] == DATA_PORT)) |=>
      (a2hCount == $past(a2hCount)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (h2aCount <= CW'(DEPTH)) && (a2hCount <= CW'(DEPTH)));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (h2aCount == CW'(DEPTH) && !(audRd && audAddr[7:0] == DATA_PORT)) |=>
      (h2aCount == CW'(DEPTH)));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (audRd && audAddr[7:0] == DATA_PORT && h2aCount == '0) |-> (audRdata == 8'hFF));

endmodule

bind mbox_dual_fifo mbox_checker #(
  .DEPTH      (DEPTH),
  .AUD_ADDR_W (AUD_ADDR_W),
  .DATA_PORT  (DATA_PORT),
  .STAT_PORT  (STAT_PORT)
) uChecker (
  .clk       (clk),
  .rst       (rst),
  .hostSel   (hostSel),
  .hostRe    (hostRe),
  .hostBe    (hostBe),
  .hostRdata (hostRdata),
  .audAddr   (audAddr),
  .audRd     (audRd),
  .audWr     (audWr),
  .audRdata  (audRdata),
  .h2aCount  (h2aCount),
  .a2hCount  (a2hCount)
);

// File: tb/tb_mbox_dual_fifo.sv
module tb_mbox_dual_fifo;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostSel = 1'b0;
  logic        hostRe = 1'b0;
  logic        hostWe = 1'b0;
  logic [3:0]  hostBe = 4'h0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [15:0] audAddr = '0;
  logic        audRd = 1'b0;
  logic        audWr = 1'b0;
  logic [7:0]  audWdata = '0;
  logic [7:0]  audRdata;

  int nVec = 0;
  int nBad = 0;
  logic [7:0] h2aQ[$];
  logic [7:0] a2hQ[$];

  always #2 clk = ~clk;

  mbox_dual_fifo dut (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostRe(hostRe), .hostWe(hostWe),
    .hostBe(hostBe), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .audAddr(audAddr), .audRd(audRd), .audWr(audWr), .audWdata(audWdata),
    .audRdata(audRdata)
  );

  function automatic logic [7:0] statByte(input int n);
    return (n == 0) ? 8'hFD : 8'hFF;
  endfunction

  function automatic logic [31:0] expHost();
    return {statByte(a2hQ.size()), 16'hFFFF, (a2hQ.size() == 0) ? 8'hFF : a2hQ[0]};
  endfunction

  function automatic logic [7:0] expAud(input logic [7:0] low);
    if (low == 8'h90) return (h2aQ.size() == 0) ? 8'hFF : h2aQ[0];
    if (low == 8'h91) return statByte(h2aQ.size());
    return 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle on both sides; outputs sampled mid-cycle
  task automatic step(input logic hs, input logic hr, input logic hw, input logic [3:0] be,
                      input logic [7:0] hwd, input logic [15:0] aa, input logic ar,
                      input logic aw, input logic [7:0] awd,
                      input string tagH, input string tagA);
    int hN;
    int aN;
    logic [7:0] d;
    @(negedge clk);
    hostSel = hs; hostRe = hr; hostWe = hw; hostBe = be;
    hostWdata = {$urandom, hwd} ;
    audAddr = aa; audRd = ar; audWr = aw; audWdata = awd;
    #1;
    if (hs && hr) check(tagH, hostRdata, expHost());
    if (ar) check(tagA, {24'h0, audRdata}, {24'h0, expAud(aa[7:0])});
    hN = h2aQ.size();
    aN = a2hQ.size();
    if (ar && aa[7:0] == 8'h90 && hN > 0) d = h2aQ.pop_front();
    if (hs && hw && be[0] && hN < DEPTH) h2aQ.push_back(hwd);
    if (hs && hr && be[0] && aN > 0) d = a2hQ.pop_front();
    if (aw && aa[7:0] == 8'h90 && aN < DEPTH) a2hQ.push_back(awd);
  endtask

  task automatic idle();
    step(0, 0, 0, 4'h0, 8'h00, 16'h0000, 0, 0, 8'h00, "", "");
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: status after reset on both sides
    step(1, 1, 0, 4'b1000, 8'h00, 16'h0091, 1, 0, 8'h00, "R1", "R1");

    // R2: host to audio ordering
    step(1, 0, 1, 4'b0001, 8'h11, 16'h0000, 0, 0, 8'h00, "R2", "R2");
    step(1, 0, 1, 4'b1111, 8'h22, 16'h0000, 0, 0, 8'h00, "R2", "R2");
    step(1, 0, 1, 4'b0001, 8'h33, 16'h0000, 0, 0, 8'h00, "R2", "R2");
    step(0, 0, 0, 4'b0000, 8'h00, 16'h0091, 1, 0, 8'h00, "R4", "R4");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 4'h0, 8'h00, 16'h0090, 1, 0, 8'h00, "R2", "R2");
    step(0, 0, 0, 4'b0000, 8'h00, 16'h0091, 1, 0, 8'h00, "R4", "R4");

    // R10: host write without data lane stores nothing
    step(1, 0, 1, 4'b1110, 8'h5A, 16'h0000, 0, 0, 8'h00, "R10", "R10");
    step(0, 0, 0, 4'b0000, 8'h00, 16'h0091, 1, 0, 8'h00, "R10", "R10");

    // R3 / R7: audio writes through aliased addresses
    step(0, 0, 0, 4'h0, 8'h00, 16'hAB90, 0, 1, 8'hA1, "R7", "R7");
    step(0, 0, 0, 4'h0, 8'h00, 16'h0090, 0, 1, 8'hA2, "R3", "R3");
    step(0, 0, 0, 4'h0, 8'h00, 16'h1292, 0, 1, 8'hEE, "R7", "R7");
    step(0, 0, 0, 4'h0, 8'h00, 16'h7792, 1, 0, 8'h00, "R7", "R7");

    // R5 / R6: status-only host reads do not pop
    step(1, 1, 0, 4'b1000, 8'h00, 16'h0000, 0, 0, 8'h00, "R6", "R6");
    step(1, 1, 0, 4'b1000, 8'h00, 16'h0000, 0, 0, 8'h00, "R5", "R5");
    step(1, 1, 0, 4'b0001, 8'h00, 16'h0000, 0, 0, 8'h00, "R3", "R3");
    step(1, 1, 0, 4'b1001, 8'h00, 16'h0000, 0, 0, 8'h00, "R3", "R3");
    step(1, 1, 0, 4'b1000, 8'h00, 16'h0000, 0, 0, 8'h00, "R5", "R5");

    // R9: empty reads on both sides
    step(1, 1, 0, 4'b0001, 8'h00, 16'h0090, 1, 0, 8'h00, "R9", "R9");
    step(0, 0, 0, 4'h0, 8'h00, 16'h3491, 1, 0, 8'h00, "R7", "R7");

    // R8: overfill the host-to-audio queue
    for (int i = 0; i < DEPTH + 6; i++)
      step(1, 0, 1, 4'b0001, 8'(i * 7 + 3), 16'h0000, 0, 0, 8'h00, "R8", "R8");
    step(0, 0, 0, 4'h0, 8'h00, 16'h0091, 1, 0, 8'h00, "R8", "R8");

    // R11: full queue, simultaneous push and pop; push refused on pre-cycle full
    step(1, 0, 1, 4'b0001, 8'hC3, 16'h0090, 1, 0, 8'h00, "R11", "R11");
    for (int i = 0; i < DEPTH + 1; i++)
      step(0, 0, 0, 4'h0, 8'h00, 16'h0090, 1, 0, 8'h00, "R8", "R8");

    // R11: empty queue, simultaneous push and pop; pop refused
    step(1, 0, 1, 4'b0001, 8'h4D, 16'h0090, 1, 0, 8'h00, "R11", "R11");
    step(1, 0, 1, 4'b0001, 8'h4E, 16'h0090, 1, 0, 8'h00, "R11", "R11");
    step(0, 0, 0, 4'h0, 8'h00, 16'h0090, 1, 0, 8'h00, "R11", "R11");
    step(0, 0, 0, 4'h0, 8'h00, 16'h0090, 1, 0, 8'h00, "R11", "R11");

    // Random traffic on both sides
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] pick;
      logic [7:0] low;
      pick = 2'($urandom_range(0, 3));
      low = (pick == 2'd0) ? 8'h91 : (pick == 2'd1) ? 8'h92 : 8'h90;
      step(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom),
           {8'($urandom), low}, 1'($urandom), 1'($urandom), 8'($urandom), "R3", "R2");
    end
    idle();
    finishRun();
  end

endmodule